// File: doc/BRIEF.md
# Access Address Mode Classifier

This block sorts every local-bus instruction or data reference into one of two kinds: a physical access that goes out untranslated, or a virtual access that must be looked up by the translation unit. Each request carries an address, an instruction/data flag, a supervisor flag and a special-cycle flag, such as an interrupt acknowledge or a debug operation. A global translation-enable input also controls the result. The address is compared against three sources of mapping: a fixed-size window that holds the translation unit's own control registers, a group of on-chip RAM base registers and a group of access control registers.

A special cycle is always physical. So is any access made while translation is disabled. Both of these take the default attribute input. When translation is enabled, the sources are searched in a fixed priority order: the control window first, then the RAM base registers, then the access control registers. Within each group the lowest index is searched first. The first register that hits supplies the attributes. An address that hits no register is virtual, and the block raises a request to the translation unit.

The decision is purely combinational. One register stage sits on the output, so every response appears exactly one clock cycle after its request.

Top module: `amc_classifier`

## Requirements
- R1: While reset is asserted and after it is released, and before any request arrives, every response output is zero. This covers `rsp_valid`, `xlat_req`, `rsp_phys`, `rsp_class`, `rsp_idx`, `rsp_attr` and `rsp_addr`.
- R2: A request sampled on one rising edge (`req_valid`=1) gives `rsp_valid`=1 after that same edge, with `rsp_addr` equal to the request address. A cycle with `req_valid`=0 gives `rsp_valid`=0 and `xlat_req`=0. Requests may arrive back to back.
- R3: A special cycle (`req_special`=1) is physical (`rsp_phys`=1) with class code 1. It has index 0, attributes equal to `dflt_attr` and `xlat_req`=0. This holds whether translation is enabled or not.
- R4: With `mmu_en`=0, a non-special access is physical with class code 0, index 0 and attributes equal to `dflt_attr`.
- R5: With `mmu_en`=1, a hit in the control window gives class code 2, index 0 and attributes `win_attr`. A window hit needs all of the following: `win_en`=1, a supervisor data access, and address bits [AW-1:WIN_LSB] equal to the same bits of `win_base`. A window hit wins over any RAM or access-control hit.
- R6: A user-mode access, or an instruction fetch, never hits the control window. Such an access is resolved by the lower-priority registers instead.
- R7: A RAM base register i hits when `ram_valid[i]`=1 and `((addr ^ base_i) & mask_i)` is zero, where a mask bit of 1 means that bit is compared. A RAM hit gives class code 3, the lowest matching index and that entry's attributes. A RAM hit wins over any access-control hit.
- R8: An access-control register hit, using the same match rule as R7, gives class code 4, the lowest matching index and that entry's attributes.
- R9: With `mmu_en`=1, an access that is not special and hits no register is virtual. It gives `rsp_phys`=0, class code 5, index 0, attributes 0 and `xlat_req`=1 in the same cycle as the response.
- R10: With `mmu_en`=1 and `req_special`=0, `dflt_attr` never appears on `rsp_attr`.
- R11: An entry whose valid bit is 0 never hits, whatever its base and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A reference is presented this cycle |
| req_addr | input | AW | Untranslated access address |
| req_is_data | input | 1 | 1 = data reference, 0 = instruction fetch |
| req_super | input | 1 | 1 = supervisor mode |
| req_special | input | 1 | Special cycle (interrupt acknowledge, debug) |
| mmu_en | input | 1 | Translation enable |
| dflt_attr | input | ATW | Default attributes used when no mapping applies |
| win_en | input | 1 | Control window enable |
| win_base | input | AW | Control window base; only bits [AW-1:WIN_LSB] are used |
| win_attr | input | ATW | Attributes for control window accesses |
| ram_valid | input | NRAM | Valid bit for each RAM base register |
| ram_base | input | NRAM*AW | RAM base addresses; entry i occupies bits [i*AW +: AW] |
| ram_mask | input | NRAM*AW | RAM compare masks (1 = bit is compared) |
| ram_attr | input | NRAM*ATW | RAM attributes; entry i occupies bits [i*ATW +: ATW] |
| acr_valid | input | NACR | Valid bit for each access control register |
| acr_base | input | NACR*AW | Access control base addresses |
| acr_mask | input | NACR*AW | Access control compare masks |
| acr_attr | input | NACR*ATW | Access control attributes |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_addr | output | AW | Address of the classified request |
| rsp_phys | output | 1 | 1 = physical, 0 = virtual |
| rsp_class | output | 3 | 0 off, 1 special, 2 window, 3 RAM, 4 access control, 5 virtual |
| rsp_idx | output | idx_w(NRAM,NACR) | Index of the winning entry within its group |
| rsp_attr | output | ATW | Attributes of the winning source |
| xlat_req | output | 1 | Request to the translation unit (virtual access) |

## Verification
The hardest case to reach is an address that hits several sources at once, where only the priority order decides the result. Examples are a supervisor data access to a window address that an access control register also covers, and two overlapping RAM or access control entries. The bench programs deliberately overlapping regions. It then sends the same address with the privilege and type flags changed. Between requests it turns entries and the window on and off and moves entries, so that each step of the priority chain becomes the winner in turn.

// File: rtl/amc_pkg.sv
package amc_pkg;

    typedef enum logic [2:0] {
        CLS_OFF     = 3'd0,
        CLS_SPECIAL = 3'd1,
        CLS_MMUWIN  = 3'd2,
        CLS_RAM     = 3'd3,
        CLS_ACR     = 3'd4,
        CLS_VIRT    = 3'd5
    } amc_class_e;

    function automatic int idx_w(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m > 1) ? $clog2(m) : 1;
    endfunction

endpackage

// File: rtl/amc_match_bank.sv
module amc_match_bank #(
    parameter int N   = 2,
    parameter int AW  = 32,
    parameter int ATW = 8,
    parameter int IW  = 1
) (
    input  logic [AW-1:0]    addr,
    input  logic [N-1:0]     valid,
    input  logic [N*AW-1:0]  base,
    input  logic [N*AW-1:0]  mask,
    input  logic [N*ATW-1:0] attr,
    output logic             hit,
    output logic [IW-1:0]    idx,
    output logic [ATW-1:0]   hit_attr
);

    logic [N-1:0] match;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign match[g] = valid[g] &&
                (((addr ^ base[g*AW +: AW]) & mask[g*AW +: AW]) == '0);
        end
    endgenerate

    // Lowest index wins: scan downward so the last assignment is the lowest hit.
    always_comb begin
        hit      = 1'b0;
        idx      = '0;
        hit_attr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                idx      = IW'(i);
                hit_attr = attr[i*ATW +: ATW];
            end
        end
    end

endmodule

// File: rtl/amc_win_match.sv
module amc_win_match #(
    parameter int AW      = 32,
    parameter int WIN_LSB = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic          en,
    input  logic          is_super,
    input  logic          is_data,
    output logic          hit
);

    localparam int TAG_W = AW - WIN_LSB;

    logic [TAG_W-1:0] addr_tag;
    logic [TAG_W-1:0] base_tag;

    assign addr_tag = addr[AW-1:WIN_LSB];
    assign base_tag = base[AW-1:WIN_LSB];
    assign hit      = en && is_super && is_data && (addr_tag == base_tag);

endmodule

// File: rtl/amc_decide.sv
module amc_decide
    import amc_pkg::*;
#(
    parameter int ATW = 8,
    parameter int IW  = 2
) (
    input  logic           mmu_en,
    input  logic           special,
    input  logic [ATW-1:0] dflt_attr,
    input  logic           win_hit,
    input  logic [ATW-1:0] win_attr,
    input  logic           ram_hit,
    input  logic [IW-1:0]  ram_idx,
    input  logic [ATW-1:0] ram_attr,
    input  logic           acr_hit,
    input  logic [IW-1:0]  acr_idx,
    input  logic [ATW-1:0] acr_attr,
    output amc_class_e     cls,
    output logic           phys,
    output logic [IW-1:0]  idx,
    output logic [ATW-1:0] attr
);

    // Fixed priority chain: overrides first, then window, RAM, access control.
    always_comb begin
        if (special)      cls = CLS_SPECIAL;
        else if (!mmu_en) cls = CLS_OFF;
        else if (win_hit) cls = CLS_MMUWIN;
        else if (ram_hit) cls = CLS_RAM;
        else if (acr_hit) cls = CLS_ACR;
        else              cls = CLS_VIRT;
    end

    always_comb begin
        phys = 1'b1;
        idx  = '0;
        attr = '0;
        unique case (cls)
            CLS_OFF, CLS_SPECIAL: attr = dflt_attr;
            CLS_MMUWIN:           attr = win_attr;
            CLS_RAM: begin
                idx  = ram_idx;
                attr = ram_attr;
            end
            CLS_ACR: begin
                idx  = acr_idx;
                attr = acr_attr;
            end
            CLS_VIRT:             phys = 1'b0;
            default:              phys = 1'b1;
        endcase
    end

endmodule

// File: rtl/amc_classifier.sv
module amc_classifier
    import amc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int ATW     = 8,
    parameter int NRAM    = 2,
    parameter int NACR    = 4,
    parameter int WIN_LSB = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    input  logic [AW-1:0]                        req_addr,
    input  logic                                 req_is_data,
    input  logic                                 req_super,
    input  logic                                 req_special,
    input  logic                                 mmu_en,
    input  logic [ATW-1:0]                       dflt_attr,
    input  logic                                 win_en,
    input  logic [AW-1:0]                        win_base,
    input  logic [ATW-1:0]                       win_attr,
    input  logic [NRAM-1:0]                      ram_valid,
    input  logic [NRAM*AW-1:0]                   ram_base,
    input  logic [NRAM*AW-1:0]                   ram_mask,
    input  logic [NRAM*ATW-1:0]                  ram_attr,
    input  logic [NACR-1:0]                      acr_valid,
    input  logic [NACR*AW-1:0]                   acr_base,
    input  logic [NACR*AW-1:0]                   acr_mask,
    input  logic [NACR*ATW-1:0]                  acr_attr,
    output logic                                 rsp_valid,
    output logic [AW-1:0]                        rsp_addr,
    output logic                                 rsp_phys,
    output logic [2:0]                           rsp_class,
    output logic [amc_pkg::idx_w(NRAM,NACR)-1:0] rsp_idx,
    output logic [ATW-1:0]                       rsp_attr,
    output logic                                 xlat_req
);

    localparam int IW = amc_pkg::idx_w(NRAM, NACR);

    logic           win_hit;
    logic           ram_hit, acr_hit;
    logic [IW-1:0]  ram_idx, acr_idx;
    logic [ATW-1:0] ram_hattr, acr_hattr;
    amc_class_e     cls_d, cls_q;
    logic           phys_d;
    logic [IW-1:0]  idx_d;
    logic [ATW-1:0] attr_d;

    amc_win_match #(.AW(AW), .WIN_LSB(WIN_LSB)) u_win (
        .addr(req_addr), .base(win_base), .en(win_en),
        .is_super(req_super), .is_data(req_is_data), .hit(win_hit)
    );

    amc_match_bank #(.N(NRAM), .AW(AW), .ATW(ATW), .IW(IW)) u_ram (
        .addr(req_addr), .valid(ram_valid), .base(ram_base), .mask(ram_mask),
        .attr(ram_attr), .hit(ram_hit), .idx(ram_idx), .hit_attr(ram_hattr)
    );

    amc_match_bank #(.N(NACR), .AW(AW), .ATW(ATW), .IW(IW)) u_acr (
        .addr(req_addr), .valid(acr_valid), .base(acr_base), .mask(acr_mask),
        .attr(acr_attr), .hit(acr_hit), .idx(acr_idx), .hit_attr(acr_hattr)
    );

    amc_decide #(.ATW(ATW), .IW(IW)) u_dec (
        .mmu_en(mmu_en), .special(req_special), .dflt_attr(dflt_attr),
        .win_hit(win_hit), .win_attr(win_attr),
        .ram_hit(ram_hit), .ram_idx(ram_idx), .ram_attr(ram_hattr),
        .acr_hit(acr_hit), .acr_idx(acr_idx), .acr_attr(acr_hattr),
        .cls(cls_d), .phys(phys_d), .idx(idx_d), .attr(attr_d)
    );

    // Output stage: one cycle of latency.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_phys  <= 1'b0;
            cls_q     <= CLS_OFF;
            rsp_idx   <= '0;
            rsp_attr  <= '0;
            xlat_req  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            xlat_req  <= req_valid && !phys_d;
            if (req_valid) begin
                rsp_addr <= req_addr;
                rsp_phys <= phys_d;
                cls_q    <= cls_d;
                rsp_idx  <= idx_d;
                rsp_attr <= attr_d;
            end
        end
    end

    assign rsp_class = cls_q;

    // R2
    no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !xlat_req));

    // R3
    special_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_special) |=>
            (rsp_valid && rsp_phys && cls_q == CLS_SPECIAL && !xlat_req));

    // R4
    off_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_special && !mmu_en) |=>
            (rsp_phys && rsp_attr == $past(dflt_attr)));

    // R6
    win_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cls_q == CLS_MMUWIN) |-> $past(req_super && req_is_data));

    // R9
    virt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_phys) |-> (xlat_req && cls_q == CLS_VIRT));

    // R10
    en_no_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mmu_en && !req_special) |=>
            (cls_q != CLS_OFF && cls_q != CLS_SPECIAL));

endmodule

// File: tb/amc_classifier_tb.sv
`timescale 1ns/1ps
module amc_classifier_tb;

    localparam int AW = 32, ATW = 8, NRAM = 2, NACR = 4, WIN_LSB = 16;
    localparam int IW = 2;

    typedef struct packed {
        logic [AW-1:0]  addr;
        logic           phys;
        logic [2:0]     cls;
        logic [IW-1:0]  idx;
        logic [ATW-1:0] attr;
        logic           xlat;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_data = 1'b0, req_super = 1'b0, req_special = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic mmu_en = 1'b0, win_en = 1'b1;
    logic [ATW-1:0] dflt_attr = 8'hA5, win_attr = 8'h11;
    logic [AW-1:0] win_base = 32'hF000_0000;
    logic [NRAM-1:0] ram_valid;
    logic [NRAM*AW-1:0] ram_base, ram_mask;
    logic [NRAM*ATW-1:0] ram_attr;
    logic [NACR-1:0] acr_valid;
    logic [NACR*AW-1:0] acr_base, acr_mask;
    logic [NACR*ATW-1:0] acr_attr;

    logic rsp_valid, rsp_phys, xlat_req;
    logic [AW-1:0] rsp_addr;
    logic [2:0] rsp_class;
    logic [IW-1:0] rsp_idx;
    logic [ATW-1:0] rsp_attr;

    int checks = 0, errors = 0;
    bit done = 0;
    item_t exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    amc_classifier #(.AW(AW), .ATW(ATW), .NRAM(NRAM), .NACR(NACR), .WIN_LSB(WIN_LSB)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_data(req_is_data), .req_super(req_super), .req_special(req_special),
        .mmu_en(mmu_en), .dflt_attr(dflt_attr), .win_en(win_en), .win_base(win_base),
        .win_attr(win_attr), .ram_valid(ram_valid), .ram_base(ram_base),
        .ram_mask(ram_mask), .ram_attr(ram_attr), .acr_valid(acr_valid),
        .acr_base(acr_base), .acr_mask(acr_mask), .acr_attr(acr_attr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_phys(rsp_phys),
        .rsp_class(rsp_class), .rsp_idx(rsp_idx), .rsp_attr(rsp_attr), .xlat_req(xlat_req)
    );

    function automatic bit hits(input logic [AW-1:0] a, input logic v,
                                input logic [AW-1:0] b, input logic [AW-1:0] m);
        return v && (((a ^ b) & m) == '0);
    endfunction

    // Expected result computed from the requirement text.
    function automatic item_t model(input logic [AW-1:0] a, input logic d,
                                    input logic s, input logic sp);
        item_t e;
        bit found;
        e = '0;
        e.addr = a;
        e.phys = 1'b1;
        if (sp) begin
            e.cls = 3'd1; e.attr = dflt_attr;                           // R3
        end else if (!mmu_en) begin
            e.cls = 3'd0; e.attr = dflt_attr;                           // R4
        end else if (win_en && s && d && a[AW-1:WIN_LSB] == win_base[AW-1:WIN_LSB]) begin
            e.cls = 3'd2; e.attr = win_attr;                            // R5
        end else begin
            found = 0;
            for (int i = 0; i < NRAM; i++)
                if (!found && hits(a, ram_valid[i], ram_base[i*AW +: AW], ram_mask[i*AW +: AW])) begin
                    found = 1; e.cls = 3'd3; e.idx = IW'(i); e.attr = ram_attr[i*ATW +: ATW];
                end
            for (int i = 0; i < NACR; i++)
                if (!found && hits(a, acr_valid[i], acr_base[i*AW +: AW], acr_mask[i*AW +: AW])) begin
                    found = 1; e.cls = 3'd4; e.idx = IW'(i); e.attr = acr_attr[i*ATW +: ATW];
                end
            if (!found) begin
                e.cls = 3'd5; e.phys = 1'b0; e.xlat = 1'b1;             // R9
            end
        end
        return e;
    endfunction

    task automatic send(input logic [AW-1:0] a, input logic d, input logic s,
                        input logic sp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_data = d; req_super = s; req_special = sp;
        exp_q.push_back(model(a, d, s, sp));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compare each response against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            item_t e, a;
            string t;
            checks++;
            a = '{rsp_addr, rsp_phys, rsp_class, rsp_idx, rsp_attr, xlat_req};
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response act=%h exp=none", a);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s addr=%h act phys=%0b cls=%0d idx=%0d attr=%h xlat=%0b exp phys=%0b cls=%0d idx=%0d attr=%h xlat=%0b",
                             t, e.addr, a.phys, a.cls, a.idx, a.attr, a.xlat,
                             e.phys, e.cls, e.idx, e.attr, e.xlat);
                end
            end
        end else if (rst_n && xlat_req) begin
            checks++; errors++;
            $display("FAIL R2 xlat_req without response act=1 exp=0");
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        ram_valid = 2'b11;
        ram_base  = {32'h2000_0000, 32'h2000_0000};
        ram_mask  = {32'hFF00_0000, 32'hFFFF_0000};
        ram_attr  = {8'h21, 8'h20};
        acr_valid = 4'b0111;
        acr_base  = {32'h6000_0000, 32'hF000_0000, 32'h2000_0000, 32'h4000_0000};
        acr_mask  = {32'hF000_0000, 32'hF000_0000, 32'hF000_0000, 32'hF000_0000};
        acr_attr  = {8'h43, 8'h42, 8'h41, 8'h40};

        repeat (3) @(negedge clk);
        checks++;   // R1 reset state, during reset
        if ({rsp_valid, xlat_req, rsp_phys, rsp_class, rsp_idx, rsp_attr, rsp_addr} !== '0) begin
            errors++;
            $display("FAIL R1 outputs in reset act=%b%b%b %0d %0d %h %h exp=0",
                     rsp_valid, xlat_req, rsp_phys, rsp_class, rsp_idx, rsp_attr, rsp_addr);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;   // R1 after release, no request yet
        if ({rsp_valid, xlat_req, rsp_attr, rsp_addr} !== '0) begin
            errors++;
            $display("FAIL R1 outputs after reset act=%b%b %h %h exp=0",
                     rsp_valid, xlat_req, rsp_attr, rsp_addr);
        end

        // R4 translation disabled
        send(32'h4000_0000, 1, 0, 0, "R4 off data");
        send(32'h0000_1234, 0, 1, 0, "R4 off instr");
        send(32'hF000_1234, 1, 1, 0, "R4 off window addr");
        // R3 special overrides disabled
        send(32'h1234_0000, 1, 1, 1, "R3 special off");
        idle(2);
        mmu_en = 1'b1;
        // R3 special overrides enabled
        send(32'h1000_0000, 1, 1, 1, "R3 special on");
        // R5 window, R6 privilege and type
        send(32'hF000_1234, 1, 1, 0, "R5 window hit");
        send(32'hF000_1234, 1, 0, 0, "R6 user data");
        send(32'hF000_1234, 0, 1, 0, "R6 super instr");
        // R7 RAM priority and lowest index
        send(32'h2000_1000, 1, 0, 0, "R7 ram0 lowest");
        send(32'h2010_0000, 1, 1, 0, "R7 ram1");
        send(32'h2FFF_0000, 0, 0, 0, "R8 acr1 below ram");
        send(32'h4000_0040, 1, 0, 0, "R8 acr0");
        // R9 virtual, R11 invalid entry, R10 no default attrs
        send(32'h6000_0000, 1, 0, 0, "R11 acr3 invalid");
        send(32'h1000_0000, 0, 1, 0, "R9 R10 virtual");
        idle(3);

        acr_valid = 4'b1111;
        send(32'h6000_0000, 1, 0, 0, "R11 acr3 now valid");
        idle(1);
        acr_base[3*AW +: AW] = 32'h4000_0000;
        send(32'h4000_0040, 1, 0, 0, "R8 lowest acr index");
        idle(1);
        win_en = 1'b0;
        send(32'hF000_1234, 1, 1, 0, "R5 window disabled");
        idle(1);
        ram_valid = 2'b10;
        send(32'h2000_1000, 1, 0, 0, "R11 ram0 invalid");
        idle(1);
        dflt_attr = 8'h42;
        send(32'h1000_0000, 1, 0, 0, "R10 virtual attr zero");
        send(32'hF000_0000, 1, 0, 0, "R10 acr2 attr");
        idle(4);

        checks++;   // R2 every request answered exactly once
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses act=%0d exp=0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule